// File: doc/BRIEF.md
# APB Write Port Feeding a Backpressured Stream Queue

This block is an APB3 subordinate whose only write target is a queue. A write to the data address appends the write data to an internal synchronous FIFO. A downstream consumer empties the FIFO over a valid/ready stream. When the FIFO has no free slot, the APB write is stalled: PREADY stays low, and nothing is stored, until the consumer takes an entry. The held write data is then appended in the cycle PREADY goes high. The append and the acknowledgement always fall on the same edge.

The number of wait cycles on a write is set only by the consumer's drain rate. The bus puts no limit on it. Each APB transfer appends exactly one entry, however long it waited. A second address returns the current fill level. Reads are answered with zero wait states. Reads of the data address return zero, and writes to any address other than the data address complete at once and change nothing.

Top module: `apb_fifo_feeder`

## Requirements
- R1: After reset the queue is empty: `q_valid` is low and a read of the status address (offset `STAT_ADDR`, default 4) returns 0.
- R2: A write to the data address (offset `DATA_ADDR`, default 0) while the queue has a free slot completes in its first access cycle and appends `pwdata` on that edge.
- R3: While the queue holds `DEPTH` entries and no entry leaves in the same cycle, an access-phase write to the data address sees `pready` low and appends nothing.
- R4: If the queue is full and an entry leaves in the same cycle as an access-phase data write, the write completes in that cycle and the fill level stays at `DEPTH`.
- R5: Each write transfer to the data address appends exactly one entry, whatever its number of wait cycles. A stalled write waits exactly as many cycles as the consumer withholds `q_ready`.
- R6: A read of the status address completes with zero wait states and returns the fill level, zero-extended, in `prdata`.
- R7: A read of the data address or of any unmapped address returns 0 with zero waits. A write to any address other than the data address completes with zero waits and leaves the fill level unchanged.
- R8: An entry leaves on every rising edge where `q_valid` and `q_ready` are both high. Entries leave in the order they were written, with `q_data` showing the oldest entry.
- R9: `q_valid` is high exactly when the fill level is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and queue clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | High for write transfers |
| paddr | input | ADDR_W | Byte offset within the block |
| pwdata | input | DATA_W | Write data, held by the manager through waits |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer completion; low stalls the access |
| q_valid | output | 1 | Queue has an entry for the consumer |
| q_ready | input | 1 | Consumer accepts the presented entry |
| q_data | output | DATA_W | Oldest queued entry |

## Verification
The bench builds the block with `DEPTH=4`, `DATA_W=16` and `ADDR_W=4`. With these values every fill level from empty to full can be reached in a few writes, and the whole 16-entry address space can be swept on both reads and writes. Stall lengths from zero to five waits are swept against a full queue, with each result compared to the release cycle the bench chose. The one-wait-free case, where an entry leaves and a write lands in the same cycle, is among them. A queue model in the bench checks the order of the entries and the count of appends per transfer.

// File: rtl/afeed_pkg.sv
package afeed_pkg;

  // Which register an access targets.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DATA = 2'd1,
    TGT_STAT = 2'd2
  } tgt_e;

endpackage

// File: rtl/afeed_decode.sv
module afeed_decode
  import afeed_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 4,
  parameter int DATA_ADDR = 0,
  parameter int STAT_ADDR = 4
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  fill,
  output tgt_e              tgt,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(STAT_ADDR);
  localparam int PAD_W = DATA_W - CNT_W;

  always_comb begin
    if (paddr == DATA_OFS) begin
      tgt = TGT_DATA;
    end else if (paddr == STAT_OFS) begin
      tgt = TGT_STAT;
    end else begin
      tgt = TGT_NONE;
    end
  end

  // Read mux: only the status register carries data.
  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        rdata = '0;
        if (tgt == TGT_STAT) begin
          rdata = {{PAD_W{1'b0}}, fill};
        end
      end
    end else begin : g_nopad
      always_comb begin
        rdata = '0;
        if (tgt == TGT_STAT) begin
          rdata = fill[DATA_W-1:0];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/afeed_handshake.sv
module afeed_handshake
  import afeed_pkg::*;
(
  input  logic psel,
  input  logic penable,
  input  logic pwrite,
  input  tgt_e tgt,
  input  logic q_full,
  input  logic pop,
  output logic pready,
  output logic push
);

  logic acc;
  logic wr_data;
  logic room;

  always_comb begin
    acc     = psel & penable;
    wr_data = acc & pwrite & (tgt == TGT_DATA);
    // A slot is free now, or one frees on this very edge.
    room    = ~q_full | pop;
    // Completion and the append share one condition, so the data is
    // stored on exactly the edge that ends the transfer.
    push    = wr_data & room;
    pready  = ~wr_data | room;
  end

endmodule

// File: rtl/afeed_fifo.sv
module afeed_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty,
  output logic [$clog2(DEPTH):0] fill
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PTR_W = IDX_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_nx;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_nx;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  always_comb begin
    wr_idx = wr_ptr[IDX_W-1:0];
    rd_idx = rd_ptr[IDX_W-1:0];
    empty  = (wr_ptr == rd_ptr);
    full   = (wr_ptr[PTR_W-1] != rd_ptr[PTR_W-1]) &&
             (wr_idx == rd_idx);
    fill   = wr_ptr - rd_ptr;
    rdata  = mem[rd_idx];
  end

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    if (push) begin
      wr_ptr_nx = wr_ptr + PTR_W'(1);
    end
    if (pop) begin
      rd_ptr_nx = rd_ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
    end
  end

  // Storage: no reset; written only on the append edge.
  always_ff @(posedge pclk) begin
    if (push) begin
      mem[wr_idx] <= wdata;
    end
  end

endmodule

// File: rtl/apb_fifo_feeder.sv
module apb_fifo_feeder
  import afeed_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 8,
  parameter int DATA_ADDR = 0,
  parameter int STAT_ADDR = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_data
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  tgt_e             tgt;
  logic             q_full;
  logic             q_empty;
  logic [CNT_W-1:0] fill_cnt;
  logic             push_fire;
  logic             pop_fire;

  always_comb begin
    q_valid  = ~q_empty;
    pop_fire = q_valid & q_ready;
  end

  afeed_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .DATA_ADDR (DATA_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_dec (
    .paddr (paddr),
    .fill  (fill_cnt),
    .tgt   (tgt),
    .rdata (prdata)
  );

  afeed_handshake u_hs (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .tgt     (tgt),
    .q_full  (q_full),
    .pop     (pop_fire),
    .pready  (pready),
    .push    (push_fire)
  );

  afeed_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_fifo (
    .pclk    (pclk),
    .presetn (presetn),
    .push    (push_fire),
    .wdata   (pwdata),
    .pop     (pop_fire),
    .rdata   (q_data),
    .full    (q_full),
    .empty   (q_empty),
    .fill    (fill_cnt)
  );

endmodule

// File: rtl/apb_fifo_feeder_chk.sv
module apb_fifo_feeder_chk #(
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 8,
  parameter int DATA_ADDR = 0,
  parameter int CNT_W     = 4
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              pready,
  input logic              q_valid,
  input logic              q_ready,
  input logic [CNT_W-1:0]  fill_cnt,
  input logic              push_fire
);

  logic wr_acc;
  logic leave;
  assign wr_acc = psel && penable && pwrite && (paddr == ADDR_W'(DATA_ADDR));
  assign leave  = q_valid && q_ready;

  // R3: full, nothing leaving -> stalled
  p_stall_full_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && fill_cnt == CNT_W'(DEPTH) && !leave) |-> !pready);

  // R3: level never exceeds depth
  p_no_overflow_r3: assert property (@(posedge pclk) disable iff (!presetn)
    fill_cnt <= CNT_W'(DEPTH));

  // R2: an append only happens on a completing data write
  p_append_on_done_r2: assert property (@(posedge pclk) disable iff (!presetn)
    push_fire |-> (wr_acc && pready));

  // R5: level rises by one after an append with nothing leaving
  p_one_append_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (push_fire && !leave) |=> fill_cnt == $past(fill_cnt) + CNT_W'(1));

  // R4: full queue with an exit and a write stays full
  p_swap_full_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && leave && fill_cnt == CNT_W'(DEPTH)) |=> fill_cnt == CNT_W'(DEPTH));

  // R6: reads never wait
  p_read_nowait_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite) |-> pready);

  // R9: valid follows the level
  p_valid_level_r9: assert property (@(posedge pclk) disable iff (!presetn)
    q_valid == (fill_cnt != '0));

endmodule

bind apb_fifo_feeder apb_fifo_feeder_chk #(
  .ADDR_W    (ADDR_W),
  .DEPTH     (DEPTH),
  .DATA_ADDR (DATA_ADDR),
  .CNT_W     (CNT_W)
) u_chk (
  .pclk      (pclk),
  .presetn   (presetn),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pready    (pready),
  .q_valid   (q_valid),
  .q_ready   (q_ready),
  .fill_cnt  (fill_cnt),
  .push_fire (push_fire)
);

// File: tb/apb_fifo_feeder_test.sv
`timescale 1ns/1ps
module apb_fifo_feeder_test;

  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEP   = 4;
  localparam int A_DAT = 0;
  localparam int A_STA = 4;

  logic          pclk;
  logic          presetn;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [DW-1:0] prdata;
  logic          pready;
  logic          q_valid;
  logic          q_ready;
  logic [DW-1:0] q_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;
  logic [DW-1:0] model_q[$];

  apb_fifo_feeder #(
    .ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP),
    .DATA_ADDR(A_DAT), .STAT_ADDR(A_STA)
  ) uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data)
  );

  initial pclk = 1'b0;
  always #10 pclk = ~pclk;   // 50 MHz

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge pclk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // Stream monitor, R8: compare each leaving entry with the model.
  always @(posedge pclk) begin
    if (presetn && q_valid && q_ready) begin
      if (model_q.size() == 0) begin
        check(0, "R8 exit from empty model", 1, 0);
      end else begin
        check(q_data == model_q[0], "R8 order", int'(q_data), int'(model_q[0]));
        void'(model_q.pop_front());
      end
    end
  end

  // One transfer; entered just after a falling edge. Returns wait count.
  task automatic apb_xfer(input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int waits);
    bit fin;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    waits = 0;
    fin = 0;
    while (!fin) begin
      #1;
      rd = prdata;
      fin = pready;
      @(posedge pclk);
      if (fin && wr && a == AW'(A_DAT)) model_q.push_back(d);
      if (!fin) waits++;
      @(negedge pclk);
    end
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic read_status(output int lvl);
    logic [DW-1:0] rd;
    int w;
    apb_xfer(1'b0, AW'(A_STA), '0, rd, w);
    lvl = int'(rd);
  endtask

  initial begin
    logic [DW-1:0] rd;
    int w;
    int lvl;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; q_ready = 0;
    presetn = 0;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset state
    #1;
    check(q_valid == 1'b0, "R1 valid after reset", int'(q_valid), 0);
    read_status(lvl);
    check(lvl == 0, "R1 level after reset", lvl, 0);

    // R2/R6/R9 fill sweep
    for (int i = 1; i <= DEP; i++) begin
      apb_xfer(1'b1, AW'(A_DAT), DW'(16'h1100 + i), rd, w);
      check(w == 0, "R2 zero waits with room", w, 0);
      apb_xfer(1'b0, AW'(A_STA), '0, rd, w);
      check(int'(rd) == i, "R6 level", int'(rd), i);
      check(w == 0, "R6 status zero waits", w, 0);
      #1;
      check(q_valid == 1'b1, "R9 valid when nonempty", int'(q_valid), 1);
    end

    // R7 read sweep over the whole address space
    for (int a = 0; a < (1 << AW); a++) begin
      apb_xfer(1'b0, AW'(a), '0, rd, w);
      if (a == A_STA) check(int'(rd) == DEP, "R6 status in sweep", int'(rd), DEP);
      else check(rd == '0, "R7 read returns zero", int'(rd), 0);
      check(w == 0, "R7 read zero waits", w, 0);
    end
    // R7 write sweep: non-data addresses never wait and never append (queue full)
    for (int a = 0; a < (1 << AW); a++) begin
      if (a != A_DAT) begin
        apb_xfer(1'b1, AW'(a), 16'hDEAD, rd, w);
        check(w == 0, "R7 other write zero waits", w, 0);
      end
    end
    read_status(lvl);
    check(lvl == DEP, "R7 level unchanged by other writes", lvl, DEP);

    // R3/R4/R5 stall sweep on a full queue
    for (int k = 1; k <= 6; k++) begin
      fork
        apb_xfer(1'b1, AW'(A_DAT), DW'(16'h2200 + k), rd, w);
        begin
          repeat (k) @(negedge pclk);
          q_ready = 1'b1;
          @(negedge pclk);
          q_ready = 1'b0;
        end
      join
      if (k == 1) check(w == 0, "R4 same-cycle exit and write", w, 0);
      else check(w == k - 1, "R3 R5 waits follow drain", w, k - 1);
      read_status(lvl);
      check(lvl == DEP, "R5 one append per transfer", lvl, DEP);
    end

    // R8 drain everything
    q_ready = 1'b1;
    repeat (DEP + 2) @(negedge pclk);
    q_ready = 1'b0;
    #1;
    check(q_valid == 1'b0, "R9 valid low when empty", int'(q_valid), 0);
    check(model_q.size() == 0, "R8 model drained", model_q.size(), 0);
    read_status(lvl);
    check(lvl == 0, "R8 level after drain", lvl, 0);

    // R8 streaming with consumer always ready, varied data patterns
    q_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      apb_xfer(1'b1, AW'(A_DAT), DW'((i * 16'h1357) ^ 16'hA5A5), rd, w);
      check(w == 0, "R2 streaming zero waits", w, 0);
    end
    repeat (3) @(negedge pclk);
    q_ready = 1'b0;
    check(model_q.size() == 0, "R8 stream fully delivered", model_q.size(), 0);

    finish_run();
  end

endmodule